// File: doc/BRIEF.md
# Cascadable Four-Bit Arithmetic/Logic Slice

This block is a purely combinational arithmetic and logic unit built from identical four-bit slices. Each slice takes two operands, a three-bit function code and a carry-in. It returns a four-bit result, a carry-out and a signed overflow flag. The eight functions are a constant zero, two subtraction directions, addition, three bitwise logic operations and a constant all-ones.

The slices ripple their carries from the least significant slice to the most significant. A cascade wrapper sets the carry injected at the bottom of the chain from the function code. The carry is 1 for either subtraction, which completes the two's complement of the inverted subtrahend, and 0 otherwise. Only the most significant slice reports overflow.

The top level joins two slices into an eight-bit unit that has no clock and no state.

Top module: `alu8_top`

## Requirements
- R1: The function code `sel` maps as follows: 0 gives constant zero, 1 gives B minus A, 2 gives A minus B, 3 gives A plus B, 4 gives A XOR B, 5 gives A OR B, 6 gives A AND B and 7 gives constant all-ones.
- R2: With `sel`=0, `f` is 0x00 and `cout` and `ovf` are 0 for every operand pair.
- R3: With `sel`=7, `f` is 0xFF and `cout` and `ovf` are 0 for every operand pair.
- R4: With `sel`=3, `f` is (A+B) mod 256 and `cout` is bit 8 of the unsigned sum. No carry is injected at the bottom of the chain.
- R5: With `sel`=2, `f` is (A-B) mod 256 and `cout` is 1 exactly when A >= B unsigned, meaning no borrow.
- R6: With `sel`=1, `f` is (B-A) mod 256 and `cout` is 1 exactly when B >= A unsigned.
- R7: With `sel` set to 4, 5 or 6, `f` is the bitwise XOR, OR or AND of A and B, and `cout` and `ovf` are 0.
- R8: For `sel` 1, 2 and 3, `ovf` is 1 exactly when the signed eight-bit result, with operands read in two's complement, lies outside -128..127. For all other codes `ovf` is 0.
- R9: The carry leaving the low slice enters the high slice. For example, 0x0F plus 0x01 gives 0x10, and 0x10 minus 0x01 gives 0x0F with `cout`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Operand A, two's complement |
| b | input | 8 | Operand B, two's complement |
| sel | input | 3 | Function code |
| f | output | 8 | Result |
| cout | output | 1 | Carry out of the top slice |
| ovf | output | 1 | Signed overflow of the whole word |

## Verification
The hardest case to reach is a carry or borrow that must cross the slice boundary while the top slice also overflows. One example is 0x7F plus 0x01, where the low carry alone flips the sign of the high nibble. Another is 0x80 minus 0x01. Cases like these only show up for particular nibble pairs. The stimulus therefore sweeps every operand pair under every function code, covering all 524,288 combinations, and compares each result against an integer model. It also runs directed checks at the nibble-crossing values.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ZERO  = 3'd0,
    OP_BSUBA = 3'd1,
    OP_ASUBB = 3'd2,
    OP_ADD   = 3'd3,
    OP_XOR   = 3'd4,
    OP_OR    = 3'd5,
    OP_AND   = 3'd6,
    OP_ONES  = 3'd7
  } alu_op_e;

  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_BSUBA) || (op == OP_ASUBB) || (op == OP_ADD);
  endfunction

  function automatic logic is_sub(input alu_op_e op);
    return (op == OP_BSUBA) || (op == OP_ASUBB);
  endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  alu_pkg::alu_op_e op,
  input  logic             cin,
  output logic [W-1:0]     f,
  output logic             cout,
  output logic             ovf
);
  import alu_pkg::*;
  localparam int MSB = W - 1;

  // Ripple adder returning {carry out, carry into MSB, sum}.
  function automatic logic [W+1:0] ripple(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic c0);
    logic [W-1:0] s;
    logic c, c_msb;
    c = c0;
    c_msb = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (i == MSB) c_msb = c;
      s[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (x[i] & c) | (y[i] & c);
    end
    return {c, c_msb, s};
  endfunction

  logic [W-1:0] opx, opy, sum;
  logic         arith, c_into_msb, c_out_msb;

  always_comb begin
    unique case (op)
      OP_BSUBA: begin opx = b; opy = ~a; end
      OP_ASUBB: begin opx = a; opy = ~b; end
      default:  begin opx = a; opy = b;  end
    endcase
  end

  assign arith = is_arith(op);
  assign {c_out_msb, c_into_msb, sum} = ripple(opx, opy, cin);

  always_comb begin
    unique case (op)
      OP_ZERO: f = '0;
      OP_ONES: f = '1;
      OP_XOR:  f = a ^ b;
      OP_OR:   f = a | b;
      OP_AND:  f = a & b;
      default: f = sum;
    endcase
  end

  assign cout = arith & c_out_msb;
  assign ovf  = arith & (c_into_msb ^ c_out_msb);

  always_comb begin
    if (op == OP_ZERO)
      a_r2_zero_const: assert (f == '0 && !cout && !ovf);
    if (op == OP_ONES)
      a_r3_ones_const: assert (f == '1 && !cout && !ovf);
    if (op == OP_XOR || op == OP_OR || op == OP_AND)
      a_r7_logic_no_flags: assert (!cout && !ovf);
    if (ovf)
      a_r8_ovf_sign_flip: assert (arith && opx[MSB] == opy[MSB] && f[MSB] != opx[MSB]);
  end

endmodule

// File: rtl/alu_cascade.sv
module alu_cascade #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2
) (
  input  logic [SLICE_W*SLICES-1:0] a,
  input  logic [SLICE_W*SLICES-1:0] b,
  input  alu_pkg::alu_op_e          op,
  output logic [SLICE_W*SLICES-1:0] f,
  output logic                      cout,
  output logic                      ovf
);
  import alu_pkg::*;

  logic [SLICES:0]   chain;
  logic [SLICES-1:0] ovf_s;

  assign chain[0] = is_sub(op);

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .a    (a[g*SLICE_W +: SLICE_W]),
      .b    (b[g*SLICE_W +: SLICE_W]),
      .op   (op),
      .cin  (chain[g]),
      .f    (f[g*SLICE_W +: SLICE_W]),
      .cout (chain[g+1]),
      .ovf  (ovf_s[g])
    );
  end

  assign cout = chain[SLICES];
  assign ovf  = ovf_s[SLICES-1];

  always_comb begin
    if (op == OP_ADD)
      a_r4_no_injected_carry: assert (chain[0] == 1'b0);
    if (is_sub(op))
      a_r9_sub_injects_carry: assert (chain[0] == 1'b1);
    if (!is_arith(op))
      a_r9_chain_quiet: assert (chain == '0 && ovf_s == '0);
  end

endmodule

// File: rtl/alu8_top.sv
module alu8_top #(
  parameter int WIDTH   = 8,
  parameter int SLICE_W = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       sel,
  output logic [WIDTH-1:0] f,
  output logic             cout,
  output logic             ovf
);
  import alu_pkg::*;
  localparam int SLICES = WIDTH / SLICE_W;

  alu_op_e op;
  assign op = alu_op_e'(sel);

  alu_cascade #(.SLICE_W(SLICE_W), .SLICES(SLICES)) u_cascade (
    .a    (a),
    .b    (b),
    .op   (op),
    .f    (f),
    .cout (cout),
    .ovf  (ovf)
  );

  always_comb begin
    if (ovf)
      a_r8_ovf_only_arith: assert (sel == 3'd1 || sel == 3'd2 || sel == 3'd3);
  end

endmodule

// File: tb/tb_alu8_top.sv
`timescale 1ns/1ps
module tb_alu8_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0] a, b, f;
  logic [2:0] sel;
  logic cout, ovf;

  alu8_top dut (.a(a), .b(b), .sel(sel), .f(f), .cout(cout), .ovf(ovf));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expect_out(input string req, input logic [7:0] ef,
                            input logic ec, input logic eo);
    checks++;
    if (f !== ef || cout !== ec || ovf !== eo) begin
      errors++;
      $display("FAIL %s sel=%0d a=%02h b=%02h: actual f=%02h c=%b v=%b expected f=%02h c=%b v=%b",
               req, sel, a, b, f, cout, ovf, ef, ec, eo);
    end
  endtask

  task automatic apply(input logic [2:0] s, input logic [7:0] x, input logic [7:0] y);
    sel = s; a = x; b = y;
    #1;
  endtask

  // Independent integer model of the function codes (R1).
  task automatic model(input int s, input int x, input int y,
                       output logic [7:0] ef, output logic ec, output logic eo,
                       output string req);
    int sx, sy, r, sr;
    sx = (x > 127) ? x - 256 : x;
    sy = (y > 127) ? y - 256 : y;
    ec = 0; eo = 0;
    case (s)
      0: begin ef = 8'h00; req = "R2"; end
      1: begin r = y - x; ef = r[7:0]; ec = (y >= x); sr = sy - sx;
               eo = (sr > 127 || sr < -128); req = "R6"; end
      2: begin r = x - y; ef = r[7:0]; ec = (x >= y); sr = sx - sy;
               eo = (sr > 127 || sr < -128); req = "R5"; end
      3: begin r = x + y; ef = r[7:0]; ec = r[8]; sr = sx + sy;
               eo = (sr > 127 || sr < -128); req = "R4"; end
      4: begin r = x ^ y; ef = r[7:0]; req = "R7"; end
      5: begin r = x | y; ef = r[7:0]; req = "R7"; end
      6: begin r = x & y; ef = r[7:0]; req = "R7"; end
      default: begin ef = 8'hFF; req = "R3"; end
    endcase
  endtask

  initial begin
    logic [7:0] ef;
    logic ec, eo;
    string req;
    sel = 3'd0; a = 8'h5A; b = 8'hA5;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R2 initial", 8'h00, 1'b0, 1'b0);

    // R9 and R8 directed cases across the slice boundary.
    apply(3'd3, 8'h0F, 8'h01); expect_out("R9 add carry", 8'h10, 1'b0, 1'b0);
    apply(3'd2, 8'h10, 8'h01); expect_out("R9 sub borrow", 8'h0F, 1'b1, 1'b0);
    apply(3'd1, 8'h01, 8'h10); expect_out("R9 rsub borrow", 8'h0F, 1'b1, 1'b0);
    apply(3'd3, 8'h7F, 8'h01); expect_out("R8 pos ovf", 8'h80, 1'b0, 1'b1);
    apply(3'd2, 8'h80, 8'h01); expect_out("R8 neg ovf", 8'h7F, 1'b1, 1'b1);
    apply(3'd3, 8'h80, 8'h80); expect_out("R8 two neg", 8'h00, 1'b1, 1'b1);
    apply(3'd3, 8'hFF, 8'h01); expect_out("R4 wrap", 8'h00, 1'b1, 1'b0);
    apply(3'd2, 8'h05, 8'h05); expect_out("R5 equal", 8'h00, 1'b1, 1'b0);
    apply(3'd7, 8'h00, 8'h00); expect_out("R3 ones", 8'hFF, 1'b0, 1'b0);
    apply(3'd6, 8'hF0, 8'h3C); expect_out("R7 and", 8'h30, 1'b0, 1'b0);

    // R1: exhaustive sweep of every code and operand pair.
    for (int s = 0; s < 8; s++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++) begin
          apply(s[2:0], x[7:0], y[7:0]);
          model(s, x, y, ef, ec, eo, req);
          expect_out({"R1 ", req}, ef, ec, eo);
        end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule